// File: doc/BRIEF.md
# MII Receive Nibble-to-Byte Frame Assembler

This block sits on the receive half of a Media Independent Interface. It runs entirely in the receive clock domain and captures the 4-bit data nibble, the data-valid strobe, the receive-error strobe and carrier sense on each rising clock edge. It packs pairs of nibbles into bytes and presents them as single-cycle beats. Each beat carries start-of-frame and end-of-frame markers, a frame error flag and an alignment flag.

Frame boundaries come from the data-valid strobe. The block keeps a carrier arming flag and accepts a new frame only after carrier sense has been seen low between frames. A frame that arrives without that gap is discarded as a whole. An error strobe raised outside a frame is ignored completely.

All decisions are taken edge by edge with no counting of clock periods. A receive clock that stops for a couple of periods around frame boundaries therefore loses nothing.

Top module: `mii_rx_assembler`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0. Out of reset the carrier flag is armed, so the first frame is accepted without a prior carrier drop.
- R2: Nibbles are packed low nibble first. The first nibble of each pair goes to `out_data[3:0]` and the second to `out_data[7:4]`. Bytes come out in arrival order, one `out_valid` beat per byte.
- R3: Every accepted frame produces exactly one beat with `out_sof`, which is its first beat, and exactly one beat with `out_eof`, which is its last beat.
- R4: If `mii_rx_er` is high on any nibble where `mii_rx_dv` is high in an accepted frame, `out_err` is 1 on that frame's end-of-frame beat. `out_err` is 0 on every other beat and on the end beat of a frame without such an error.
- R5: `mii_rx_er` sampled while `mii_rx_dv` is low produces no beat and does not affect the error flag of any later frame.
- R6: A frame with an odd nibble count ends with a beat whose `out_data[7:4]` is 0 and whose low half is the last nibble, with `out_align` = 1. `out_align` is 0 on every other beat, including the end beat of an even-length frame.
- R7: A frame is accepted only if `mii_crs` was sampled low, with `mii_rx_dv` low, at some point after the start of the previous frame. Otherwise none of the frame's nibbles produce a beat.
- R8: Stopping `rx_clk` for up to two periods just before a frame's first nibble and just after its last nibble leaves the produced beats unchanged.
- R9: A one-nibble frame produces a single beat with `out_sof`, `out_eof` and `out_align` all set.
- R10: With the default single input stage, no beat appears once `mii_rx_dv` has been sampled low on three consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive clock from the PHY (25 MHz or 2.5 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| mii_rxd | input | 4 | Receive data nibble |
| mii_rx_dv | input | 1 | Receive data valid; high for the whole frame |
| mii_rx_er | input | 1 | Receive error strobe |
| mii_crs | input | 1 | Carrier sense |
| out_valid | output | 1 | One-cycle beat strobe |
| out_data | output | 8 | Assembled byte |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_err | output | 1 | Frame saw an in-band error (end beat only) |
| out_align | output | 1 | Frame ended on a half byte (end beat only) |

## Verification
The packing path is driven with even and odd frames of several lengths, including one-nibble and two-nibble frames. These separate nibble ordering, pending-byte handling and partial-byte padding. An error strobe is placed in mid-frame and again outside any frame, which shows sticky in-band marking apart from out-of-band filtering. Back-to-back frames with carrier held high and with carrier dropped show that rejection depends on the carrier gap. A frame framed by stopped-clock intervals shows that no period counting is involved.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

    parameter int NIB_W = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef struct packed {
        logic [NIB_W-1:0] rxd;
        logic             dv;
        logic             er;
        logic             crs;
    } mii_smp_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sof;
        logic              eof;
        logic              err;
        logic              align;
    } rx_beat_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_TAKE = 2'd1,
        FS_DROP = 2'd2
    } frame_st_e;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] lo,
        input logic [NIB_W-1:0] hi
    );
        return {hi, lo};
    endfunction

    function automatic logic [BYTE_W-1:0] pad_nibble(input logic [NIB_W-1:0] lo);
        return {{NIB_W{1'b0}}, lo};
    endfunction

    function automatic rx_beat_t make_beat(
        input logic [BYTE_W-1:0] data,
        input logic              sof,
        input logic              eof,
        input logic              err,
        input logic              align
    );
        rx_beat_t b;
        b.data  = data;
        b.sof   = sof;
        b.eof   = eof;
        b.err   = err;
        b.align = align;
        return b;
    endfunction

endpackage

// File: rtl/mii_rx_sampler.sv
module mii_rx_sampler
    import mii_rx_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] rxd,
    input  logic             dv,
    input  logic             er,
    input  logic             crs,
    output mii_smp_t         cur,
    output logic             start_pulse,
    output logic             end_pulse
);

    mii_smp_t stg [IN_STAGES];
    mii_smp_t raw;
    logic     dv_prev;

    always_comb begin
        raw.rxd = rxd;
        raw.dv  = dv;
        raw.er  = er;
        raw.crs = crs;
    end

    for (genvar g = 0; g < IN_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= '0;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dv_prev <= 1'b0;
        else     dv_prev <= stg[IN_STAGES-1].dv;
    end

    assign cur         = stg[IN_STAGES-1];
    assign start_pulse = cur.dv & ~dv_prev;
    assign end_pulse   = ~cur.dv & dv_prev;

endmodule

// File: rtl/mii_rx_carrier_gate.sv
module mii_rx_carrier_gate
    import mii_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mii_smp_t cur,
    input  logic     start_pulse,
    output logic     accept,
    output logic     armed
);

    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
        end else if (start_pulse) begin
            armed_q <= 1'b0;
        end else if (!cur.dv && !cur.crs) begin
            armed_q <= 1'b1;
        end
    end

    assign armed  = armed_q;
    assign accept = start_pulse & armed_q;

endmodule

// File: rtl/mii_rx_packer.sv
module mii_rx_packer
    import mii_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mii_smp_t cur,
    input  logic     start_pulse,
    input  logic     accept,
    output logic     beat_valid,
    output rx_beat_t beat
);

    frame_st_e         st_q;
    logic [NIB_W-1:0]  low_q;
    logic [BYTE_W-1:0] pend_q;
    logic              odd_q;
    logic              has_pend_q;
    logic              first_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= FS_IDLE;
            low_q      <= '0;
            pend_q     <= '0;
            odd_q      <= 1'b0;
            has_pend_q <= 1'b0;
            first_q    <= 1'b0;
            err_q      <= 1'b0;
            beat_valid <= 1'b0;
            beat       <= '0;
        end else begin
            beat_valid <= 1'b0;
            case (st_q)
                FS_IDLE: begin
                    if (start_pulse) begin
                        if (accept) begin
                            st_q       <= FS_TAKE;
                            low_q      <= cur.rxd;
                            odd_q      <= 1'b1;
                            has_pend_q <= 1'b0;
                            first_q    <= 1'b1;
                            err_q      <= cur.er;
                        end else begin
                            st_q <= FS_DROP;
                        end
                    end
                end
                FS_TAKE: begin
                    if (cur.dv) begin
                        err_q <= err_q | cur.er;
                        if (odd_q) begin
                            pend_q     <= join_nibbles(low_q, cur.rxd);
                            has_pend_q <= 1'b1;
                            odd_q      <= 1'b0;
                        end else begin
                            low_q <= cur.rxd;
                            odd_q <= 1'b1;
                            if (has_pend_q) begin
                                beat_valid <= 1'b1;
                                beat       <= make_beat(pend_q, first_q, 1'b0, 1'b0, 1'b0);
                                first_q    <= 1'b0;
                                has_pend_q <= 1'b0;
                            end
                        end
                    end else begin
                        st_q       <= FS_IDLE;
                        beat_valid <= 1'b1;
                        if (odd_q) begin
                            beat <= make_beat(pad_nibble(low_q), first_q, 1'b1, err_q, 1'b1);
                        end else begin
                            beat <= make_beat(pend_q, first_q, 1'b1, err_q, 1'b0);
                        end
                        first_q    <= 1'b0;
                        has_pend_q <= 1'b0;
                        odd_q      <= 1'b0;
                    end
                end
                FS_DROP: begin
                    if (!cur.dv) st_q <= FS_IDLE;
                end
                default: st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mii_rx_assembler.sv
module mii_rx_assembler
    import mii_rx_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input  logic              rx_clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  mii_rxd,
    input  logic              mii_rx_dv,
    input  logic              mii_rx_er,
    input  logic              mii_crs,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_err,
    output logic              out_align
);

    mii_smp_t smp;
    logic     start_pulse;
    logic     end_pulse;
    logic     accept;
    logic     armed;
    logic     bv;
    rx_beat_t bt;

    mii_rx_sampler #(.IN_STAGES(IN_STAGES)) u_smp (
        .clk         (rx_clk),
        .rst         (rst),
        .rxd         (mii_rxd),
        .dv          (mii_rx_dv),
        .er          (mii_rx_er),
        .crs         (mii_crs),
        .cur         (smp),
        .start_pulse (start_pulse),
        .end_pulse   (end_pulse)
    );

    mii_rx_carrier_gate u_gate (
        .clk         (rx_clk),
        .rst         (rst),
        .cur         (smp),
        .start_pulse (start_pulse),
        .accept      (accept),
        .armed       (armed)
    );

    mii_rx_packer u_pack (
        .clk         (rx_clk),
        .rst         (rst),
        .cur         (smp),
        .start_pulse (start_pulse),
        .accept      (accept),
        .beat_valid  (bv),
        .beat        (bt)
    );

    logic unused_ok;
    assign unused_ok = end_pulse ^ armed;

    assign out_valid = bv;
    assign out_data  = bt.data;
    assign out_sof   = bt.sof;
    assign out_eof   = bt.eof;
    assign out_err   = bt.err;
    assign out_align = bt.align;

endmodule

// File: rtl/mii_rx_assembler_chk.sv
module mii_rx_assembler_chk
    import mii_rx_pkg::*;
#(
    parameter int IN_STAGES = 1
) (
    input logic              rx_clk,
    input logic              rst,
    input logic              mii_rx_dv,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_err,
    input logic              out_align
);

    logic       open_q;
    logic [3:0] idle_cnt;

    always_ff @(posedge rx_clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (out_valid) begin
            if (out_eof)      open_q <= 1'b0;
            else if (out_sof) open_q <= 1'b1;
        end
    end

    always_ff @(posedge rx_clk) begin
        if (rst || mii_rx_dv) idle_cnt <= '0;
        else if (idle_cnt != 4'hF) idle_cnt <= idle_cnt + 4'd1;
    end

    p_mid_beat_clean_r4: assert property (@(posedge rx_clk) disable iff (rst)
        (out_valid && !out_eof) |-> (!out_err && !out_align));

    p_align_pad_r6: assert property (@(posedge rx_clk) disable iff (rst)
        (out_valid && out_align) |-> (out_data[BYTE_W-1:NIB_W] == '0));

    p_sof_once_r3: assert property (@(posedge rx_clk) disable iff (rst)
        (out_valid && out_sof) |-> !open_q);

    p_eof_closes_r3: assert property (@(posedge rx_clk) disable iff (rst)
        (out_valid && out_eof) |-> (open_q || out_sof));

    p_beat_in_frame_r3: assert property (@(posedge rx_clk) disable iff (rst)
        (out_valid && !out_sof) |-> open_q);

    p_quiet_idle_r10: assert property (@(posedge rx_clk) disable iff (rst)
        (idle_cnt >= 4'(IN_STAGES + 2)) |-> !out_valid);

endmodule

bind mii_rx_assembler mii_rx_assembler_chk #(.IN_STAGES(IN_STAGES)) u_chk (
    .rx_clk    (rx_clk),
    .rst       (rst),
    .mii_rx_dv (mii_rx_dv),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_err   (out_err),
    .out_align (out_align)
);

// File: tb/tb_mii_rx_assembler.sv
module tb_mii_rx_assembler;

    logic       rx_clk = 1'b0;
    logic       clk_run = 1'b1;
    logic       rst = 1'b1;
    logic [3:0] mii_rxd = '0;
    logic       mii_rx_dv = 1'b0;
    logic       mii_rx_er = 1'b0;
    logic       mii_crs = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_sof, out_eof, out_err, out_align;

    typedef struct {
        logic [7:0] data;
        bit         sof;
        bit         eof;
        bit         err;
        bit         align;
        string      tag;
    } exp_t;

    exp_t  q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    armed_m = 1'b1;

    always begin
        #4;
        if (clk_run) rx_clk = ~rx_clk;
    end

    mii_rx_assembler dut (
        .rx_clk    (rx_clk),
        .rst       (rst),
        .mii_rxd   (mii_rxd),
        .mii_rx_dv (mii_rx_dv),
        .mii_rx_er (mii_rx_er),
        .mii_crs   (mii_crs),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_sof   (out_sof),
        .out_eof   (out_eof),
        .out_err   (out_err),
        .out_align (out_align)
    );

    // Scoreboard monitor
    always @(negedge rx_clk) begin
        exp_t e;
        if (!rst && out_valid) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL %s R5 R7: unexpected beat data=%h sof=%0b eof=%0b, expected none",
                         cur_tag, out_data, out_sof, out_eof);
            end else begin
                e = q.pop_front();
                if (out_data !== e.data || out_sof !== e.sof || out_eof !== e.eof ||
                    out_err !== e.err || out_align !== e.align) begin
                    n_bad++;
                    $display("FAIL %s: got d=%h sof=%0b eof=%0b err=%0b al=%0b expected d=%h sof=%0b eof=%0b err=%0b al=%0b",
                             e.tag, out_data, out_sof, out_eof, out_err, out_align,
                             e.data, e.sof, e.eof, e.err, e.align);
                end
            end
        end
    end

    task automatic pause_clk();
        clk_run = 1'b0;
        #16;
        clk_run = 1'b1;
    endtask

    task automatic send_frame(input logic [63:0] nibs, input int n, input int er_at,
                              input bit drop_crs, input bit pauses, input string tag);
        bit acc;
        int nb;
        exp_t e;
        acc     = armed_m;
        armed_m = 1'b0;
        cur_tag = tag;
        if (acc) begin
            nb = (n + 1) / 2;
            for (int i = 0; i < nb; i++) begin
                if (2*i + 1 < n) e.data = {nibs[4*(2*i+1) +: 4], nibs[8*i +: 4]};
                else             e.data = {4'h0, nibs[8*i +: 4]};
                e.sof   = (i == 0);
                e.eof   = (i == nb - 1);
                e.err   = e.eof && (er_at >= 0);
                e.align = e.eof && (n % 2 == 1);
                e.tag   = tag;
                q.push_back(e);
            end
        end
        @(negedge rx_clk);
        if (pauses) pause_clk();
        for (int i = 0; i < n; i++) begin
            if (i > 0) @(negedge rx_clk);
            mii_rxd   = nibs[4*i +: 4];
            mii_rx_dv = 1'b1;
            mii_crs   = 1'b1;
            mii_rx_er = (i == er_at);
        end
        @(negedge rx_clk);
        mii_rx_dv = 1'b0;
        mii_rx_er = 1'b0;
        mii_rxd   = '0;
        if (pauses) pause_clk();
        if (drop_crs) begin
            mii_crs = 1'b0;
            armed_m = 1'b1;
        end
        @(negedge rx_clk);
        @(negedge rx_clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge rx_clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge rx_clk);
        // R1: nothing during reset
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%0b during reset expected 0", out_valid);
        end
        rst = 1'b0;
        mii_crs = 1'b1;
        @(negedge rx_clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: out_valid=%0b after reset expected 0", out_valid);
        end

        // R1 armed out of reset, R2 ordering with 8 nibbles
        send_frame(64'h0000_0000_8765_4321, 8, -1, 1'b1, 1'b0, "R1 R2");
        // R6 odd length
        send_frame(64'h0000_0000_000A_BCDE, 5, -1, 1'b1, 1'b0, "R6");
        // R4 in-band error
        send_frame(64'h0000_0000_00F0_E1D2, 6, 2, 1'b1, 1'b0, "R4");

        // R5 out-of-band error strobes
        cur_tag = "R5";
        @(negedge rx_clk);
        mii_rx_er = 1'b1;
        repeat (3) @(negedge rx_clk);
        mii_crs = 1'b1;
        repeat (2) @(negedge rx_clk);
        mii_rx_er = 1'b0;
        mii_crs = 1'b0;
        @(negedge rx_clk);
        send_frame(64'h0000_0000_0013_579B, 6, -1, 1'b1, 1'b0, "R5");

        // R7 carrier held high between frames
        send_frame(64'h0000_0000_0000_5AA5, 4, -1, 1'b0, 1'b0, "R7 keep");
        send_frame(64'h0000_0000_0099_9999, 6, -1, 1'b1, 1'b0, "R7 reject");
        send_frame(64'h0000_0000_0000_C3C3, 4, 0, 1'b1, 1'b0, "R7 rearm");

        // R9 single nibble
        send_frame(64'h0000_0000_0000_0007, 1, -1, 1'b1, 1'b0, "R9");
        // R8 clock stops around boundaries
        send_frame(64'h0000_0000_0765_4321, 7, -1, 1'b1, 1'b1, "R8");
        // R2 minimal even frame
        send_frame(64'h0000_0000_0000_00B6, 2, -1, 1'b1, 1'b0, "R2 short");

        repeat (6) @(negedge rx_clk);
        // R3: every expected beat delivered
        n_cmp++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R3: %0d beats missing expected 0", q.size());
        end
        summary();
        $finish;
    end

endmodule